// File: doc/BRIEF.md
# Routed Level-Sensitive Interrupt Controller

This block collects nine level-sensitive interrupt sources and presents them on three interrupt request outputs that feed a host interrupt controller. Every source input is first brought into the local clock domain by a two-stage synchroniser. A polarity setting then turns it into an internal "active" flag. Some sources have their polarity configurable, and others have it fixed in hardware.

Each output line owns a control word. The low half of that word holds a per-source enable mask. The upper half reports a pending flag for every source, and software writes ones there to clear them. A pending flag is captured whenever its source is active, whatever the enable says. An output asserts, one cycle later, whenever any pending flag that is also enabled is set on its line. Software reads one word to see all nine pending flags of a line at once, services the highest-numbered one first, and writes a one to the matching acknowledge bit. A source that is still active sets its flag again straight away. A start-up write of `0x01FF0000` to each line word disables everything and clears the pending flags.

The register port is a plain 32-bit write strobe with a byte offset. Reads are combinational from the offset.

Top module: `rlic_top`

## Requirements
- R1: After reset, `irq_o` is 0, every line word (offsets 0x4, 0x8, 0xC) reads 0, and the polarity word (offset 0x0) reads 0x102: configurable sources are active-low, sources 1 and 8 are active-high, and source 2 is active-low.
- R2: A write to offset 0x0 stores bit n as the polarity of source n (1 = active-high, 0 = active-low) for sources 0 and 3 to 7. Bits 1, 2 and 8 ignore the write and stay at 1, 0 and 1. The word reads back at offset 0x0, bits [8:0].
- R3: A change on `src_i` is visible in the pending bits of a read after the third rising clock edge, and on `irq_o` after the fourth.
- R4: The pending flag of source n in every line is set, and reads as bit 16+n of that line's word, whenever source n is active, whether or not it is enabled.
- R5: A write to the line word at offset 0x4+4*n replaces enable bits [8:0] of line n, and those bits read back in the same positions.
- R6: Writing 1 to bit 16+n of a line word clears pending flag n of that line only. A 0 in that bit leaves the flag unchanged, and other lines are unaffected.
- R7: A pending flag whose source is still active when it is acknowledged stays set.
- R8: `irq_o[n]` equals, one cycle later, the OR over all sources of pending AND enable of line n.
- R9: Offsets other than 0x0, 0x4, 0x8 and 0xC read zero, and writes to them change nothing. Bits 31:25 and 15:9 of every word read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 9 | Raw interrupt source levels, asynchronous |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 3 | Interrupt request lines, active-high |

## Verification
Register reads depend only on the current state, so the bench drives the offset on the falling edge and compares the read data one time step later. A write takes effect at the next rising edge. A source change reaches the pending bits three edges later, two synchroniser stages and then the pending register, and reaches `irq_o` one edge after that. A bench model advances on the same edges, so every read and output comparison is made in the cycle the result is due. The directed checks count those edges one at a time to pin the latency.

// File: rtl/rlic_pkg.sv
package rlic_pkg;
    localparam int RLIC_NUM_SRC   = 9;
    localparam int RLIC_NUM_LINES = 3;
    localparam int RLIC_DATA_W    = 32;
    localparam int RLIC_ADDR_W    = 6;
    localparam int RLIC_PEND_LSB  = 16;
    localparam int RLIC_POL_OFF   = 0;
    localparam int RLIC_LINE_BASE = 4;
    localparam int RLIC_LINE_STEP = 4;
    // sources whose sensing is wired in, and the value they are wired to
    localparam logic [RLIC_NUM_SRC-1:0] RLIC_FIXED_MASK = 9'h106;
    localparam logic [RLIC_NUM_SRC-1:0] RLIC_FIXED_VAL  = 9'h102;

    function automatic int line_offset(input int line);
        return RLIC_LINE_BASE + RLIC_LINE_STEP * line;
    endfunction
endpackage

// File: rtl/rlic_src_cond.sv
// Two-stage synchroniser, polarity register and level normalisation.
module rlic_src_cond #(
    parameter int NUM_SRC = 9,
    parameter logic [NUM_SRC-1:0] FIXED_MASK = '0,
    parameter logic [NUM_SRC-1:0] FIXED_VAL  = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               pol_we_i,
    input  logic [NUM_SRC-1:0] pol_wdata_i,
    output logic [NUM_SRC-1:0] pol_o,
    output logic [NUM_SRC-1:0] act_o
);
    localparam logic [NUM_SRC-1:0] POL_RST  = FIXED_MASK & FIXED_VAL;
    localparam logic [NUM_SRC-1:0] IDLE_LVL = ~POL_RST;

    logic [NUM_SRC-1:0] meta_q;
    logic [NUM_SRC-1:0] sync_q;
    logic [NUM_SRC-1:0] pol_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= IDLE_LVL;
            sync_q <= IDLE_LVL;
        end else begin
            meta_q <= src_i;
            sync_q <= meta_q;
        end
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_pol
        if (FIXED_MASK[i]) begin : g_fixed
            assign pol_q[i] = FIXED_VAL[i];
        end else begin : g_cfg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pol_q[i] <= 1'b0;
                end else if (pol_we_i) begin
                    pol_q[i] <= pol_wdata_i[i];
                end
            end
        end
    end

    // active when the synchronised level equals the selected polarity
    assign act_o = ~(sync_q ^ pol_q);
    assign pol_o = pol_q;
endmodule

// File: rtl/rlic_line.sv
// One output line: enable mask, pending flags, registered request.
module rlic_line #(
    parameter int NUM_SRC = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] act_i,
    input  logic               wr_i,
    input  logic [NUM_SRC-1:0] en_wdata_i,
    input  logic [NUM_SRC-1:0] ack_wdata_i,
    output logic [NUM_SRC-1:0] en_o,
    output logic [NUM_SRC-1:0] pend_o,
    output logic               irq_o
);
    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] clr;
    logic               irq_q;

    assign clr = wr_i ? ack_wdata_i : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            pend_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            if (wr_i) begin
                en_q <= en_wdata_i;
            end
            // a still-active level wins over the clear
            pend_q <= (pend_q & ~clr) | act_i;
            irq_q  <= |(pend_q & en_q);
        end
    end

    assign en_o   = en_q;
    assign pend_o = pend_q;
    assign irq_o  = irq_q;
endmodule

// File: rtl/rlic_top.sv
module rlic_top
    import rlic_pkg::*;
#(
    parameter int NUM_SRC   = RLIC_NUM_SRC,
    parameter int NUM_LINES = RLIC_NUM_LINES,
    parameter int DATA_W    = RLIC_DATA_W,
    parameter int ADDR_W    = RLIC_ADDR_W,
    parameter int PEND_LSB  = RLIC_PEND_LSB
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   src_i,
    input  logic                 we_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [DATA_W-1:0]    wdata_i,
    output logic [DATA_W-1:0]    rdata_o,
    output logic [NUM_LINES-1:0] irq_o
);
    localparam logic [ADDR_W-1:0] POL_ADDR = ADDR_W'(RLIC_POL_OFF);

    logic                          pol_hit;
    logic [NUM_SRC-1:0]            pol_q;
    logic [NUM_SRC-1:0]            src_act;
    logic [NUM_LINES-1:0]          line_hit;
    logic [NUM_LINES*NUM_SRC-1:0]  pend_all;
    logic [NUM_LINES*NUM_SRC-1:0]  en_all;
    logic [DATA_W-1:0]             line_word [NUM_LINES];

    assign pol_hit = (addr_i == POL_ADDR);

    rlic_src_cond #(
        .NUM_SRC    (NUM_SRC),
        .FIXED_MASK (RLIC_FIXED_MASK),
        .FIXED_VAL  (RLIC_FIXED_VAL)
    ) u_cond (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (src_i),
        .pol_we_i    (we_i && pol_hit),
        .pol_wdata_i (wdata_i[NUM_SRC-1:0]),
        .pol_o       (pol_q),
        .act_o       (src_act)
    );

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        localparam logic [ADDR_W-1:0] LINE_ADDR = ADDR_W'(line_offset(l));

        assign line_hit[l] = (addr_i == LINE_ADDR);

        rlic_line #(
            .NUM_SRC (NUM_SRC)
        ) u_line (
            .clk         (clk),
            .rst_n       (rst_n),
            .act_i       (src_act),
            .wr_i        (we_i && line_hit[l]),
            .en_wdata_i  (wdata_i[NUM_SRC-1:0]),
            .ack_wdata_i (wdata_i[PEND_LSB +: NUM_SRC]),
            .en_o        (en_all[l*NUM_SRC +: NUM_SRC]),
            .pend_o      (pend_all[l*NUM_SRC +: NUM_SRC]),
            .irq_o       (irq_o[l])
        );

        always_comb begin
            line_word[l]                     = '0;
            line_word[l][NUM_SRC-1:0]        = en_all[l*NUM_SRC +: NUM_SRC];
            line_word[l][PEND_LSB +: NUM_SRC] = pend_all[l*NUM_SRC +: NUM_SRC];
        end
    end

    always_comb begin
        rdata_o = '0;
        if (pol_hit) begin
            rdata_o[NUM_SRC-1:0] = pol_q;
        end
        for (int l = 0; l < NUM_LINES; l++) begin
            if (line_hit[l]) begin
                rdata_o = line_word[l];
            end
        end
    end
endmodule

// File: rtl/rlic_chk.sv
module rlic_chk
    import rlic_pkg::*;
#(
    parameter int NUM_SRC   = RLIC_NUM_SRC,
    parameter int NUM_LINES = RLIC_NUM_LINES,
    parameter int DATA_W    = RLIC_DATA_W,
    parameter int ADDR_W    = RLIC_ADDR_W,
    parameter int PEND_LSB  = RLIC_PEND_LSB
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         we_i,
    input logic [ADDR_W-1:0]            addr_i,
    input logic [DATA_W-1:0]            wdata_i,
    input logic [DATA_W-1:0]            rdata_o,
    input logic [NUM_LINES-1:0]         irq_o,
    input logic [NUM_SRC-1:0]           src_act,
    input logic [NUM_LINES*NUM_SRC-1:0] pend_all,
    input logic [NUM_LINES*NUM_SRC-1:0] en_all
);
    // R2: wired polarity bits always read back at their fixed values
    assert_fixed_pol_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == ADDR_W'(RLIC_POL_OFF)) |->
            ((rdata_o[NUM_SRC-1:0] & RLIC_FIXED_MASK) == (RLIC_FIXED_MASK & RLIC_FIXED_VAL)));

    // R9: reserved fields read zero
    assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata_o[DATA_W-1:PEND_LSB+NUM_SRC] == '0) && (rdata_o[PEND_LSB-1:NUM_SRC] == '0));

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_l
        // R8: request is the registered OR of enabled pending flags
        assert_irq_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (irq_o[l] == $past(|(pend_all[l*NUM_SRC +: NUM_SRC] & en_all[l*NUM_SRC +: NUM_SRC]))));

        // R7 and R4: an active source is pending on every line next cycle
        assert_pend_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> ((pend_all[l*NUM_SRC +: NUM_SRC] & $past(src_act)) == $past(src_act)));

        for (genvar n = 0; n < NUM_SRC; n++) begin : g_n
            // R6: acknowledging an inactive source clears its flag
            assert_ack_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (we_i && addr_i == ADDR_W'(line_offset(l)) && wdata_i[PEND_LSB+n] && !src_act[n])
                    |=> !pend_all[l*NUM_SRC+n]);
        end
    end
endmodule

bind rlic_top rlic_chk #(
    .NUM_SRC   (NUM_SRC),
    .NUM_LINES (NUM_LINES),
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .PEND_LSB  (PEND_LSB)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .irq_o    (irq_o),
    .src_act  (src_act),
    .pend_all (pend_all),
    .en_all   (en_all)
);

// File: tb/rlic_top_tb.sv
module rlic_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 9;
    localparam int NL = 3;
    localparam logic [NS-1:0] FIX_MASK = 9'h106;
    localparam logic [NS-1:0] FIX_VAL  = 9'h102;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  src = ~FIX_VAL;
    logic        we = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [2:0]  irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rlic_top u_dut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .we_i(we), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
    );

    // requirement-level model, advanced on the same edges
    logic [NS-1:0] m_s1, m_s2, m_pol;
    logic [NS-1:0] m_en [NL];
    logic [NS-1:0] m_pend [NL];
    logic [NL-1:0] m_irq;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 <= ~FIX_VAL; m_s2 <= ~FIX_VAL; m_pol <= FIX_VAL;
            m_irq <= '0;
            for (int l = 0; l < NL; l++) begin m_en[l] <= '0; m_pend[l] <= '0; end
        end else begin
            logic [NS-1:0] act;
            act = ~(m_s2 ^ m_pol);
            m_s1 <= src; m_s2 <= m_s1;
            if (we && addr == 6'd0) m_pol <= (wdata[8:0] & ~FIX_MASK) | FIX_VAL;
            for (int l = 0; l < NL; l++) begin
                logic hit;
                hit = we && (addr == 6'(4 + 4*l));
                m_irq[l] <= |(m_pend[l] & m_en[l]);
                m_pend[l] <= (m_pend[l] & ~(hit ? wdata[24:16] : 9'h0)) | act;
                if (hit) m_en[l] <= wdata[8:0];
            end
        end
    end

    function automatic logic [31:0] exp_read(input logic [5:0] a);
        logic [31:0] r;
        r = '0;
        if (a == 6'd0) r[8:0] = m_pol;
        for (int l = 0; l < NL; l++)
            if (a == 6'(4 + 4*l)) begin r[8:0] = m_en[l]; r[24:16] = m_pend[l]; end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act_v, input logic [31:0] exp_v);
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act_v, exp_v);
        end
    endtask

    // one cycle: drive at falling edge, compare, then let the rising edge pass
    task automatic step(input logic w, input logic [5:0] a, input logic [31:0] d,
                        input logic [8:0] s, input string req);
        @(negedge clk);
        we = w; addr = a; wdata = d; src = s;
        #1;
        check({req, " read"}, rdata, exp_read(a));
        check("R8 irq", {29'b0, irq}, {29'b0, m_irq});
        @(posedge clk);
    endtask

    task automatic peek(input logic [5:0] a, input string req, input logic [31:0] exp_v);
        @(negedge clk);
        we = 1'b0; addr = a;
        #1;
        check(req, rdata, exp_v);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [8:0] s;
        void'($urandom(32'h1f2e3d4c));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        peek(6'h0, "R1 polarity reset", 32'h102);
        peek(6'h4, "R1 line0 reset", 32'h0);
        peek(6'h8, "R1 line1 reset", 32'h0);
        peek(6'hC, "R1 line2 reset", 32'h0);
        check("R1 irq reset", {29'b0, irq}, 32'h0);

        // R2 fixed bits ignore writes
        step(1'b1, 6'h0, 32'hFFFF_FFFF, ~FIX_VAL, "R2");
        peek(6'h0, "R2 all-ones polarity", 32'h1FB);
        step(1'b1, 6'h0, 32'h0, ~FIX_VAL, "R2");
        peek(6'h0, "R2 all-zero polarity", 32'h102);

        // all sources active-high; src=0 leaves only source 2 active
        step(1'b1, 6'h0, 32'h1FF, 9'h000, "R2");
        repeat (3) step(1'b0, 6'h4, 32'h0, 9'h000, "R4");
        step(1'b1, 6'h4, 32'h01FF_0020, 9'h000, "R5");
        step(1'b1, 6'h8, 32'h01FF_0000, 9'h000, "R6");
        step(1'b1, 6'hC, 32'h01FF_0000, 9'h000, "R6");
        peek(6'h4, "R7 source2 re-sets after ack, R5 enable", 32'h0004_0020);

        // R3 latency: raise source 5 and count edges
        @(negedge clk); src = 9'h020;
        @(posedge clk);
        peek(6'h4, "R3 after edge 1", 32'h0004_0020);
        @(posedge clk);
        peek(6'h4, "R3 after edge 2", 32'h0004_0020);
        check("R3 irq low at edge 2", {29'b0, irq}, 32'h0);
        @(posedge clk);
        peek(6'h4, "R3 pending after edge 3", 32'h0024_0020);
        check("R3 irq low at edge 3", {29'b0, irq}, 32'h0);
        @(posedge clk);
        #1 check("R3 irq high at edge 4", {29'b0, irq}, 32'h1);
        peek(6'h8, "R4 pending on disabled line", 32'h0024_0000);

        // R6 ack with zero bits and on another line
        @(negedge clk); src = 9'h000;
        repeat (4) @(posedge clk);
        step(1'b1, 6'h8, 32'h0000_0000, 9'h000, "R6");
        peek(6'h8, "R6 zero ack leaves flag", 32'h0024_0000);
        step(1'b1, 6'h8, 32'h0020_0000, 9'h000, "R6");
        peek(6'h8, "R6 ack clears line1 bit5", 32'h0004_0000);
        peek(6'h4, "R6 line0 untouched", 32'h0024_0020);

        // R9 unmapped offsets
        step(1'b1, 6'h10, 32'hFFFF_FFFF, 9'h000, "R9");
        peek(6'h10, "R9 unmapped read", 32'h0);
        peek(6'h2, "R9 misaligned read", 32'h0);
        peek(6'h4, "R9 unmapped write no effect", 32'h0024_0020);

        // random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            logic [5:0] a;
            logic [31:0] d;
            case ($urandom % 7)
                0: a = 6'h0; 1: a = 6'h4; 2: a = 6'h8; 3: a = 6'hC;
                4: a = 6'h10; 5: a = 6'h6; default: a = 6'h4;
            endcase
            d = $urandom;
            if ((i % 16) < 12) s = src; else s = 9'($urandom);
            step(($urandom % 4) == 0, a, d, s, "R4 R5 R6 R9 random");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule